// File: doc/BRIEF.md
# Two-Phase GPIO Register Write Sequencer

This block drives a 32-bit GPIO output word that feeds up to four small write-only register banks. A host asks for a write by giving a bank number, a 3-bit register offset and a 5-bit value. The block first puts the offset and value on the bus with every bank enable low. It then waits out a minimum setup time, counted in clock cycles. Only after that does it raise the one enable that belongs to the chosen bank, and the offset and value stay put while it does so.

Each write changes only the offset, enable and data bits of the GPIO word. Every other output bit keeps the idle pattern set by a parameter. The host sees a ready level, a one-cycle done pulse and a one-cycle error pulse for bank numbers outside 1 to 4. The enable stays high after a write and is cleared by the phase-one update of the next accepted request.

Top module: `gpio_wr_seq`

## Requirements
- R1: While in reset and right after it, gpio_o equals GPIO_IDLE with bits [31:27] and [15:9] cleared, ready_o is 1, and done_o and err_o are 0.
- R2: Bits of gpio_o outside [31:27] and [15:9] always equal the matching bits of GPIO_IDLE.
- R3: One cycle after a request is accepted (req_valid_i high while ready_o is 1, bank 1 to 4), gpio_o[11:9] holds the offset, gpio_o[31:27] holds the data, gpio_o[15:12] is 0 and ready_o is 0.
- R4: The enable field gpio_o[15:12] is one-hot or zero. Bank 1 sets bit 15, bank 2 sets bit 14, bank 3 sets bit 13 and bank 4 sets bit 12.
- R5: The enable turns on exactly SETUP_CYCLES = ceil(SETUP_PS / CLK_PERIOD_PS) cycles after the phase-one word appears (21 cycles at the defaults). Until then the enables stay 0 and the offset and data stay unchanged.
- R6: done_o is high for exactly the one cycle in which the enable first shows, and ready_o returns to 1 in that same cycle. The enable and fields then hold until the next accepted request.
- R7: If an accepted request has a bank number of 0, 5, 6 or 7, err_o pulses for one cycle on the next cycle, gpio_o does not change and ready_o stays 1.
- R8: A request presented while ready_o is 0 is ignored. It changes neither gpio_o nor the write in progress, and it raises no err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Write request strobe |
| req_bank_i | input | 3 | Target bank number, valid values 1 to 4 |
| req_offset_i | input | 3 | Register offset within the bank |
| req_data_i | input | 5 | Value to write |
| ready_o | output | 1 | Idle and able to accept a request |
| done_o | output | 1 | One-cycle pulse when the enable is raised |
| err_o | output | 1 | One-cycle pulse for an invalid bank number |
| gpio_o | output | 32 | GPIO output word |

## Verification
The assertions check these properties on every cycle:
- the enable field is never more than one-hot;
- the bits outside the write fields never leave the idle pattern;
- phase one always clears the enables;
- before an enable rises, the fields have been quiet for the whole setup window;
- done and error are single-cycle pulses, and an error never touches the bus.

The bench scenarios are needed for the rest: the exact bank-to-bit mapping, the exact cycle on which the enable appears, the enable holding across idle time until the next request, and requests made while busy being ignored. Each of these needs a known request sequence and expected words computed outside the design.

// File: rtl/gwr_pkg.sv
package gwr_pkg;
  localparam int GPIO_W   = 32;
  localparam int OFF_W    = 3;
  localparam int DATA_W   = 5;
  localparam int NBANK    = 4;
  localparam int BANK_W   = 3;
  localparam int ADDR_LSB = 9;
  localparam int EN_LSB   = ADDR_LSB + OFF_W;
  localparam int DATA_LSB = 27;

  typedef enum logic {ST_IDLE, ST_SETUP} seq_state_e;

  function automatic logic [GPIO_W-1:0] field_mask(input int lsb, input int w);
    logic [GPIO_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam logic [GPIO_W-1:0] OFF_MASK  = field_mask(ADDR_LSB, OFF_W);
  localparam logic [GPIO_W-1:0] EN_MASK   = field_mask(EN_LSB, NBANK);
  localparam logic [GPIO_W-1:0] DATA_MASK = field_mask(DATA_LSB, DATA_W);
  localparam logic [GPIO_W-1:0] WR_MASK   = OFF_MASK | EN_MASK | DATA_MASK;
endpackage

// File: rtl/gwr_bank_decode.sv
module gwr_bank_decode #(
  parameter int NB = 4,
  parameter int BW = 3
) (
  input  logic [BW-1:0] bank_i,
  output logic          valid_o,
  output logic [NB-1:0] en_o
);
  // bank 1 maps to the MSB of the enable field
  for (genvar g = 0; g < NB; g++) begin : g_en
    assign en_o[NB-1-g] = (bank_i == BW'(g + 1));
  end
  assign valid_o = |en_o;
endmodule

// File: rtl/gwr_setup_timer.sv
module gwr_setup_timer #(
  parameter int CYCLES = 21
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);

  a_r5_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);
endmodule

// File: rtl/gwr_bus_reg.sv
module gwr_bus_reg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic q_b;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q_b <= RST_VAL[b];
      else if (we_i && mask_i[b])  q_b <= val_i[b];
    end
    assign q_o[b] = q_b;
  end
endmodule

// File: rtl/gpio_wr_seq.sv
module gpio_wr_seq
  import gwr_pkg::*;
#(
  parameter int                CLK_PERIOD_PS = 8000,
  parameter int                SETUP_PS      = 166000,
  parameter logic [GPIO_W-1:0] GPIO_IDLE     = 32'h0406_0103
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [GPIO_W-1:0] gpio_o
);
  localparam int SETUP_RAW    = (SETUP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SETUP_CYCLES = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam logic [GPIO_W-1:0] RST_WORD = GPIO_IDLE & ~WR_MASK;

  seq_state_e        st_q;
  logic              accept, bank_ok, start, bad, expire;
  logic [NBANK-1:0]  dec_en, en_q;
  logic              done_q, err_q;
  logic              bus_we;
  logic [GPIO_W-1:0] bus_mask, bus_val, p1_word, p2_word;

  assign ready_o = (st_q == ST_IDLE);
  assign accept  = req_valid_i && ready_o;

  gwr_bank_decode #(.NB(NBANK), .BW(BANK_W)) u_dec (
    .bank_i  (req_bank_i),
    .valid_o (bank_ok),
    .en_o    (dec_en)
  );

  assign start = accept && bank_ok;
  assign bad   = accept && !bank_ok;

  gwr_setup_timer #(.CYCLES(SETUP_CYCLES)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .expire_o (expire)
  );

  // phase one: fields loaded, enables cleared; phase two: enables only
  assign p1_word  = (GPIO_W'(req_offset_i) << ADDR_LSB) | (GPIO_W'(req_data_i) << DATA_LSB);
  assign p2_word  = GPIO_W'(en_q) << EN_LSB;
  assign bus_we   = start || expire;
  assign bus_mask = start ? WR_MASK : EN_MASK;
  assign bus_val  = start ? p1_word : p2_word;

  gwr_bus_reg #(.W(GPIO_W), .RST_VAL(RST_WORD)) u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bus_we),
    .mask_i (bus_mask),
    .val_i  (bus_val),
    .q_o    (gpio_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      en_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= expire;
      err_q  <= bad;
      if (start) en_q <= dec_en;
      case (st_q)
        ST_IDLE:  if (start)  st_q <= ST_SETUP;
        ST_SETUP: if (expire) st_q <= ST_IDLE;
        default:              st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  // ---------------- assertions ----------------
  localparam int HW = $clog2(SETUP_CYCLES + 1);
  logic [HW-1:0]     hold_q;
  logic [GPIO_W-1:0] fld_prev_q;
  logic [GPIO_W-1:0] fld_now;
  assign fld_now = gpio_o & (OFF_MASK | DATA_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      fld_prev_q <= '0;
    end else begin
      fld_prev_q <= fld_now;
      if ((gpio_o & EN_MASK) != '0 || fld_now != fld_prev_q) hold_q <= '0;
      else if (hold_q != HW'(SETUP_CYCLES))                  hold_q <= hold_q + 1'b1;
    end
  end

  a_r4_en_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gpio_o[EN_LSB +: NBANK]));

  a_r2_rest_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_o & ~WR_MASK) == (GPIO_IDLE & ~WR_MASK));

  a_r3_phase1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (gpio_o[EN_LSB +: NBANK] == '0) && !ready_o);

  a_r5_setup_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|gpio_o[EN_LSB +: NBANK]) |-> (int'(hold_q) >= SETUP_CYCLES - 1));

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_with_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (|gpio_o[EN_LSB +: NBANK]) && ready_o);

  a_r7_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(gpio_o) && ready_o && !done_o);

  a_r8_busy_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ready_o) |=> !err_o);
endmodule

// File: tb/gpio_wr_seq_tb.sv
`timescale 1ns/1ps
module gpio_wr_seq_tb;
  localparam int CLK_PS = 8000;
  localparam int SETUP  = 166000;
  localparam logic [31:0] IDLE = 32'h0406_0103;
  localparam logic [31:0] WRM  = 32'hF800_FE00;
  localparam int N = (SETUP + CLK_PS - 1) / CLK_PS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_bank = '0;
  logic [2:0]  req_off = '0;
  logic [4:0]  req_data = '0;
  logic        ready, done, err;
  logic [31:0] gpio;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_gpio;
  int unsigned seed_v;

  always #4 clk = ~clk;

  gpio_wr_seq #(.CLK_PERIOD_PS(CLK_PS), .SETUP_PS(SETUP), .GPIO_IDLE(IDLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_bank_i(req_bank),
    .req_offset_i(req_off), .req_data_i(req_data), .ready_o(ready), .done_o(done),
    .err_o(err), .gpio_o(gpio)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_p1(input logic [31:0] prev, input logic [2:0] off,
                                         input logic [4:0] d);
    logic [31:0] r;
    r = prev;
    r[15:12] = 4'b0000;
    r[11:9]  = off;
    r[31:27] = d;
    return r;
  endfunction

  function automatic logic [3:0] exp_en(input logic [2:0] bank);
    return 4'b1000 >> (bank - 3'd1);
  endfunction

  task automatic do_write(input logic [2:0] bank, input logic [2:0] off,
                          input logic [4:0] d, input bit poke);
    @(negedge clk);
    req_valid = 1'b1; req_bank = bank; req_off = off; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    exp_gpio = exp_p1(exp_gpio, off, d);
    chk("R3 phase-one word", gpio, exp_gpio);
    chk("R3 ready low", {31'b0, ready}, 32'd0);
    for (int i = 1; i < N; i++) begin
      if (poke && i == 2) begin
        req_valid = 1'b1; req_bank = (bank == 3'd1) ? 3'd6 : 3'd1;
        req_off = ~off; req_data = ~d;
      end
      if (i == 3) req_valid = 1'b0;
      @(negedge clk);
      chk("R5 setup hold", gpio, exp_gpio);
      if (poke) chk("R8 no err while busy", {31'b0, err}, 32'd0);
    end
    @(negedge clk);
    exp_gpio[15:12] = exp_en(bank);
    chk("R4 R5 enable word", gpio, exp_gpio);
    chk("R6 done pulse", {31'b0, done}, 32'd1);
    chk("R6 ready back", {31'b0, ready}, 32'd1);
    @(negedge clk);
    chk("R6 done one cycle", {31'b0, done}, 32'd0);
    chk("R6 enable held", gpio, exp_gpio);
    chk("R2 other bits", gpio & ~WRM, IDLE & ~WRM);
  endtask

  task automatic do_bad(input logic [2:0] bank);
    @(negedge clk);
    req_valid = 1'b1; req_bank = bank; req_off = 3'd5; req_data = 5'h15;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 err pulse", {31'b0, err}, 32'd1);
    chk("R7 bus unchanged", gpio, exp_gpio);
    chk("R7 ready stays", {31'b0, ready}, 32'd1);
    @(negedge clk);
    chk("R7 err one cycle", {31'b0, err}, 32'd0);
    chk("R7 bus still unchanged", gpio, exp_gpio);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    seed_v = $urandom(32'd4242);
    exp_gpio = IDLE & ~WRM;
    repeat (3) @(negedge clk);
    chk("R1 gpio in reset", gpio, exp_gpio);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gpio after reset", gpio, exp_gpio);
    chk("R1 ready", {31'b0, ready}, 32'd1);
    chk("R1 done/err low", {30'b0, done, err}, 32'd0);

    // directed corners
    do_write(3'd1, 3'd0, 5'h00, 1'b0);
    do_write(3'd2, 3'd7, 5'h1F, 1'b0);
    do_write(3'd3, 3'd5, 5'h0A, 1'b1);
    do_write(3'd4, 3'd2, 5'h15, 1'b0);
    do_write(3'd4, 3'd2, 5'h15, 1'b0);
    do_bad(3'd0);
    do_bad(3'd5);
    do_bad(3'd6);
    do_bad(3'd7);
    do_write(3'd1, 3'd7, 5'h11, 1'b1);

    // idle gap: enable must stay up
    repeat (7) @(negedge clk);
    chk("R6 enable held over idle", gpio, exp_gpio);

    for (int k = 0; k < 40; k++) begin
      logic [2:0] b;
      b = 3'($urandom_range(0, 7));
      if (b >= 3'd1 && b <= 3'd4)
        do_write(b, 3'($urandom_range(0, 7)), 5'($urandom_range(0, 31)), ($urandom_range(0, 3) == 0));
      else
        do_bad(b);
    end
    finish_run();
  end
endmodule